// File: doc/BRIEF.md
# Processor Power Management Controller

This block turns one 32-bit power control word into clock-enable and supply-request signals for a processor. Software writes the word through a plain write strobe and can read it back at any time. A 4-bit slow-down ratio thins the enable that reaches the core's internal units, so the core keeps full function at a lower effective rate. Two further bits pick a low-power state. The light state, doze, stops every internal unit except the tick timer and the interrupt controller. The deep state, sleep, stops everything and also asks the supply to drop.

Any interrupt from the interrupt controller ends either low-power state. The controller clears both state bits in its register, so software can read back that the core is running again. The outputs are level enables meant for clock-gating cells and a regulator that sit outside this block. The control word is register state, not a stream, so every pin is a plain control or status signal.

Top module: `pm_power_ctrl`

## Requirements
- R1: After reset the register reads 0, `core_clk_en` is high on every cycle, `tt_pic_clk_en` is high and `supply_low_req` is low.
- R2: The field layout is: ratio in bits 3:0, doze bit in bit 4, sleep bit in bit 5. A write stores bits 5:0 of `reg_wr_data`, and bits 31:6 always read as 0.
- R3: In run state (bits 5:4 both 0) with ratio N, `core_clk_en` is high on one cycle out of every N+1. It is high on the first cycle after a write, and N=0 gives full rate.
- R4: With the doze bit set and the sleep bit clear, `core_clk_en` is low, `tt_pic_clk_en` is high and `supply_low_req` is low.
- R5: With the sleep bit set, `core_clk_en` and `tt_pic_clk_en` are low and `supply_low_req` is high.
- R6: When both the doze and sleep bits are set, the outputs follow the sleep state.
- R7: If `irq_in` is high on a clock edge while the doze or sleep bit is set and no write occurs, both bits read 0 after that edge, the ratio is kept, and the outputs return to run state.
- R8: In run state, `irq_in` changes neither the register nor the enable pattern.
- R9: When a write and `irq_in` fall on the same edge, the written value is stored.
- R10: On the first run cycle after a wake, `core_clk_en` is high, and the N+1 period restarts from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Value to write |
| reg_rd_data | output | 32 | Current control word |
| irq_in | input | 1 | Any pending interrupt from the interrupt controller |
| core_clk_en | output | 1 | Enable for internal units other than the timer and interrupt controller |
| tt_pic_clk_en | output | 1 | Enable for the tick timer and interrupt controller |
| supply_low_req | output | 1 | Request to lower the core supply |

## Verification
The checker tests the following on every cycle:
- In each state, the enables match the register bits. Sleep stops everything, and doze keeps only the timer and interrupt enable.
- Bits 31:6 read as zero.
- A write lands unchanged in the register, even when an interrupt arrives on the same edge.
- An interrupt clears the state bits, and in run state it leaves the register alone.
- The run-state gap between enable pulses never exceeds the ratio.

The exact pulse phase needs the bench's scenarios. These include the first pulse after a write or a wake, the full N+1 cadence at several ratios, and the ratio kept across a wake.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_REG_W  = 32;
  localparam int PM_SDF_W  = 4;
  localparam int PM_SDF_LO = 0;
  localparam int PM_DOZE_B = PM_SDF_LO + PM_SDF_W;
  localparam int PM_SLEEP_B = PM_DOZE_B + 1;
  localparam int PM_USED_W = PM_SLEEP_B + 1;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_DOZE  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_mode_e;

  typedef struct packed {
    logic sleep_en;
    logic doze_en;
    logic [PM_SDF_W-1:0] ratio;
  } pm_ctrl_t;
endpackage

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_pkg::*;
#(
  parameter int REG_W = PM_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wake,
  output pm_ctrl_t         ctrl,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - PM_USED_W;

  pm_ctrl_t ctrl_q;
  pm_ctrl_t ctrl_d;
  logic     in_low_power;

  assign in_low_power = ctrl_q.doze_en | ctrl_q.sleep_en;

  // Write wins over a wake on the same edge.
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.ratio    = wr_data[PM_SDF_LO +: PM_SDF_W];
      ctrl_d.doze_en  = wr_data[PM_DOZE_B];
      ctrl_d.sleep_en = wr_data[PM_SLEEP_B];
    end else if (wake && in_low_power) begin
      ctrl_d.doze_en  = 1'b0;
      ctrl_d.sleep_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, ctrl_q};
    end else begin : g_nopad
      assign rd_data = ctrl_q[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pm_mode_dec.sv
module pm_mode_dec
  import pm_pkg::*;
(
  input  pm_ctrl_t ctrl,
  output pm_mode_e mode
);
  // Sleep has priority over doze.
  always_comb begin
    if (ctrl.sleep_en)     mode = PM_SLEEP;
    else if (ctrl.doze_en) mode = PM_DOZE;
    else                   mode = PM_RUN;
  end
endmodule

// File: rtl/pm_slow_div.sv
module pm_slow_div #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               hold,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart||hold) cnt_q <= '0;
    else if (cnt_q >= ratio) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == '0) && !hold;
endmodule

// File: rtl/pm_gate_ctrl.sv
module pm_gate_ctrl
  import pm_pkg::*;
(
  input  pm_mode_e mode,
  input  logic     slow_tick,
  output logic     core_en,
  output logic     timer_pic_en,
  output logic     supply_low
);
  always_comb begin
    core_en      = 1'b0;
    timer_pic_en = 1'b0;
    supply_low   = 1'b0;
    unique case (mode)
      PM_RUN: begin
        core_en      = slow_tick;
        timer_pic_en = 1'b1;
      end
      PM_DOZE: begin
        timer_pic_en = 1'b1;
      end
      PM_SLEEP: begin
        supply_low = 1'b1;
      end
      default: begin
        core_en      = 1'b0;
        timer_pic_en = 1'b0;
        supply_low   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_pkg::*;
#(
  parameter int REG_W = PM_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             irq_in,
  output logic             core_clk_en,
  output logic             tt_pic_clk_en,
  output logic             supply_low_req
);
  pm_ctrl_t ctrl;
  pm_mode_e mode;
  logic     slow_tick;
  logic     gated;

  pm_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .wake    (irq_in),
    .ctrl    (ctrl),
    .rd_data (reg_rd_data)
  );

  pm_mode_dec u_dec (
    .ctrl (ctrl),
    .mode (mode)
  );

  assign gated = (mode != PM_RUN);

  pm_slow_div #(.RATIO_W(PM_SDF_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reg_wr_en),
    .hold    (gated),
    .ratio   (ctrl.ratio),
    .tick    (slow_tick)
  );

  pm_gate_ctrl u_gate (
    .mode         (mode),
    .slow_tick    (slow_tick),
    .core_en      (core_clk_en),
    .timer_pic_en (tt_pic_clk_en),
    .supply_low   (supply_low_req)
  );
endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk
  import pm_pkg::*;
#(
  parameter int REG_W = PM_REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wr_data,
  input logic [REG_W-1:0] reg_rd_data,
  input logic             irq_in,
  input logic             core_clk_en,
  input logic             tt_pic_clk_en,
  input logic             supply_low_req
);
  logic                run_st;
  logic [PM_SDF_W:0]   gap_q;
  logic [PM_SDF_W-1:0] ratio_rd;

  assign run_st   = (reg_rd_data[PM_SLEEP_B] == 1'b0) && (reg_rd_data[PM_DOZE_B] == 1'b0);
  assign ratio_rd = reg_rd_data[PM_SDF_LO +: PM_SDF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap_q <= '0;
    else if (!run_st || core_clk_en) gap_q <= '0;
    else                          gap_q <= gap_q + 1'b1;
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[REG_W-1:PM_USED_W] == '0);

  assert_write_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data[PM_USED_W-1:0] == $past(reg_wr_data[PM_USED_W-1:0]));

  assert_slow_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && !core_clk_en) |-> (gap_q < {1'b0, ratio_rd}));

  assert_doze_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[PM_DOZE_B] && !reg_rd_data[PM_SLEEP_B]) |->
      (!core_clk_en && tt_pic_clk_en && !supply_low_req));

  assert_sleep_gating_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[PM_SLEEP_B] |-> (!core_clk_en && !tt_pic_clk_en && supply_low_req));

  assert_wake_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !reg_wr_en && !run_st) |=>
      (reg_rd_data[PM_SLEEP_B:PM_DOZE_B] == 2'b00 && ratio_rd == $past(ratio_rd)));

  assert_run_irq_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !reg_wr_en && run_st) |=> $stable(reg_rd_data));
endmodule

bind pm_power_ctrl pm_power_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_wr_data    (reg_wr_data),
  .reg_rd_data    (reg_rd_data),
  .irq_in         (irq_in),
  .core_clk_en    (core_clk_en),
  .tt_pic_clk_en  (tt_pic_clk_en),
  .supply_low_req (supply_low_req)
);

// File: tb/sim_pm_power_ctrl.sv
module sim_pm_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        irq_in = 1'b0;
  logic        core_clk_en;
  logic        tt_pic_clk_en;
  logic        supply_low_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_power_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .irq_in(irq_in), .core_clk_en(core_clk_en),
    .tt_pic_clk_en(tt_pic_clk_en), .supply_low_req(supply_low_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Checks all three enables at once: {core, tt_pic, supply}.
  task automatic chk_out(string req, logic [2:0] exp);
    chk(req, {29'd0, core_clk_en, tt_pic_clk_en, supply_low_req}, {29'd0, exp});
  endtask

  // Write on one cycle; returns at the negedge of the first cycle after it.
  task automatic write_reg(logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wr_data = '0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq_in = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
  endtask

  // Samples 3*(n+1) consecutive cycles starting with the current one.
  task automatic chk_cadence(string req, int n);
    int bad = 0;
    for (int i = 0; i < 3*(n+1); i++) begin
      if (core_clk_en !== ((i % (n+1)) == 0)) bad++;
      if (i != 3*(n+1)-1) @(negedge clk);
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 reg", reg_rd_data, 32'h0);
    chk_out("R1 outs", 3'b110);
    @(negedge clk);
    chk_out("R1 outs full rate", 3'b110);
  endtask

  task automatic t_readback();
    write_reg(32'hFFFF_FFC7);
    chk("R2 readback", reg_rd_data, 32'h0000_0007);
    write_reg(32'h0000_0000);
    chk("R2 cleared", reg_rd_data, 32'h0);
  endtask

  task automatic t_slow();
    write_reg(32'h0);
    chk_cadence("R3 N=0", 0);
    write_reg(32'h3);
    chk_cadence("R3 N=3", 3);
    write_reg(32'hF);
    chk_cadence("R3 N=15", 15);
    write_reg(32'h1);
    chk_cadence("R3 N=1", 1);
  endtask

  task automatic t_doze();
    write_reg(32'h12);
    chk_out("R4 doze", 3'b010);
    repeat (3) @(negedge clk);
    chk_out("R4 doze held", 3'b010);
    pulse_irq();
    chk("R7 doze wake reg", reg_rd_data, 32'h2);
    chk_out("R7 doze wake outs", 3'b110);
  endtask

  task automatic t_sleep();
    write_reg(32'h23);
    chk_out("R5 sleep", 3'b001);
    repeat (2) @(negedge clk);
    chk_out("R5 sleep held", 3'b001);
    pulse_irq();
    chk("R7 sleep wake reg", reg_rd_data, 32'h3);
    chk_cadence("R10 cadence after wake", 3);
  endtask

  task automatic t_both();
    write_reg(32'h31);
    chk_out("R6 both bits", 3'b001);
    pulse_irq();
    chk("R7 both wake reg", reg_rd_data, 32'h1);
  endtask

  task automatic t_run_irq();
    write_reg(32'h2);
    @(negedge clk);
    irq_in = 1'b1;
    chk_out("R8 run irq cycle 1", 3'b010);
    @(negedge clk);
    chk_out("R8 run irq cycle 2", 3'b010);
    @(negedge clk);
    irq_in = 1'b0;
    chk_out("R8 run irq cycle 3", 3'b110);
    chk("R8 run irq reg", reg_rd_data, 32'h2);
  endtask

  task automatic t_wr_irq();
    write_reg(32'h10);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = 32'h25;
    irq_in = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    irq_in = 1'b0;
    chk("R9 write beats irq", reg_rd_data, 32'h25);
    chk_out("R9 sleep entered", 3'b001);
    pulse_irq();
    chk("R7 ratio kept", reg_rd_data, 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_slow();
    t_doze();
    t_sleep();
    t_both();
    t_run_irq();
    t_wr_irq();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule